// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Step Stop Period

This block serializes characters onto an asynchronous line. A baud generator outside the block supplies a one-cycle enable pulse at sixteen times the bit rate. Each character goes out as a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and a high stop period. The stop period is programmable in sixteenths of a bit time.

A one-entry holding register sits in front of the shift register, so software or a bus bridge can queue the next character while the current one is on the line. Transmission can wait for a clear-to-send input. A request-to-send output can be driven by the block so that it covers exactly the span of queued and in-flight characters. The mode inputs are captured when each character is loaded into the shifter.

Top module: `uart_tx_fstop`

## Requirements
- R1: After a synchronous reset `txd` is 1, `tx_rdy` is 0 (transmitter disabled), `tx_emt` is 1 and `rts` is 0.
- R2: A frame is a start bit at 0 lasting 16 ticks of `tick16`, then the data bits LSB first for 16 ticks each, with `char_len` 0/1/2/3 selecting 5/6/7/8 bits, then the stop period at 1.
- R3: `par_mode` 0 appends a parity bit (`par_odd` 0 gives an even count of ones over the data and parity bits, 1 an odd count). `par_mode` 1 appends a fixed bit equal to `par_odd`. `par_mode` 2 or 3 sends no parity bit.
- R4: With `stop_code` n, the stop period lasts 9+n ticks for n below 8 and 17+n ticks for n of 8 or more. When a held character is waiting, it starts on the tick that ends the stop period, so the time from one start edge to the next is 16 times the bit count plus the stop ticks.
- R5: For 5-bit characters with `stop_code` below 8, 8 ticks are added to the stop period.
- R6: `cmd_en` enables the transmitter and `cmd_dis` disables it, with disable taking priority when both are given. While the transmitter is disabled `tx_rdy` is 0 and writes are ignored.
- R7: `tx_rdy` is 1 when the transmitter is enabled and the holding register is empty. A write is accepted only while `tx_rdy` is 1, and a write while the holding register is full is discarded.
- R8: `tx_emt` is 1 only when both the holding register and the shifter are empty, and the line is then high.
- R9: With `cts_gate` at 1, a character is loaded only when `cts` is 1. `cts` is sampled only at character boundaries, so dropping it mid-character does not shorten that character.
- R10: A disable given while a character is in flight still lets the current character and any held character go out. The line then stays high.
- R11: With `rts_auto` at 1, `rts` rises the cycle after a write is accepted. It stays high across back-to-back characters and falls when the last stop period ends with the holding register empty. With `rts_auto` at 0, `rts` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| wr_en | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character to send |
| cmd_en | input | 1 | Enable transmitter command |
| cmd_dis | input | 1 | Disable transmitter command |
| cts | input | 1 | Clear to send, 1 = asserted |
| cts_gate | input | 1 | Require `cts` before starting a character |
| rts_auto | input | 1 | Automatic request-to-send control |
| char_len | input | 2 | Character length code (5 + value bits) |
| par_mode | input | 2 | 0 parity, 1 forced bit, 2/3 none |
| par_odd | input | 1 | Odd parity / forced bit value |
| stop_code | input | 4 | Stop period code |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can take a character |
| tx_emt | output | 1 | Holding and shift registers both empty |
| rts | output | 1 | Request to send, 1 = asserted |

## Verification
The main function is driven with a table of pairs of characters queued back to back. The pairs cover every character length, all three parity behaviours with both polarities, and stop codes from both halves of the range, with and without the 5-bit extension. The sampled bit centres separate errors in bit order, length and parity. The start-to-start tick gap separates errors in stop length, including mixing up the 9+n and 17+n branches and applying the half-bit extension in the wrong place. Directed sequences then cover CTS held low and dropped mid-frame, disabling during a frame, writes to a full or disabled holding register, and the automatic RTS span across two characters.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS   = 16;   // ticks per bit
  localparam int CNT_W = 6;    // wide enough for the longest stop period (32)

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_t;

  // stop period in ticks of the 16x enable
  function automatic logic [CNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                   input logic       five_bit);
    logic [CNT_W-1:0] t;
    t = {2'b00, code};
    if (code[3]) t = t + CNT_W'(OVS + 1);
    else         t = t + CNT_W'(OVS / 2 + 1);
    if (five_bit && !code[3]) t = t + CNT_W'(OVS / 2);
    return t;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          enabled,
  output logic          hold_full,
  output logic [DW-1:0] hold_data,
  output logic          accept
);
  assign accept = wr_en & enabled & ~hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled   <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (cmd_dis)     enabled <= 1'b0;
      else if (cmd_en) enabled <= 1'b1;
      if (take)        hold_full <= 1'b0;
      else if (accept) hold_full <= 1'b1;
      if (accept)      hold_data <= wr_data;
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          cts,
  input  logic          cts_gate,
  input  logic [1:0]    char_len,
  input  logic [1:0]    par_mode,
  input  logic          par_odd,
  input  logic [3:0]    stop_code,
  output logic          take,
  output logic          frame_done,
  output logic          busy,
  output logic          txd
);
  localparam int IDX_W = $clog2(DW);

  tx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] f_stop;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] f_last;
  logic [DW-1:0]    shreg;
  logic             f_par_en;
  logic             f_par_bit;
  logic [DW-1:0]    masked;
  logic             start_ok;
  logic             bit_end;
  logic             stop_end;

  always_comb begin
    for (int i = 0; i < DW; i++)
      masked[i] = hold_data[i] & (i < 5 + int'(char_len));
  end

  assign start_ok   = hold_full & (~cts_gate | cts);
  assign bit_end    = (cnt == CNT_W'(OVS - 1));
  assign stop_end   = (state == ST_STOP) && (cnt == f_stop - CNT_W'(1));
  assign take       = tick & start_ok & ((state == ST_IDLE) | stop_end);
  assign frame_done = tick & stop_end;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      f_stop    <= '0;
      bit_idx   <= '0;
      f_last    <= '0;
      shreg     <= '0;
      f_par_en  <= 1'b0;
      f_par_bit <= 1'b0;
      txd       <= 1'b1;
    end else if (tick) begin
      if (take) begin
        shreg     <= hold_data;
        f_last    <= IDX_W'(4) + IDX_W'(char_len);
        f_par_en  <= ~par_mode[1];
        f_par_bit <= par_mode[0] ? par_odd : ((^masked) ^ par_odd);
        f_stop    <= stop_ticks(stop_code, char_len == 2'd0);
        state     <= ST_START;
        cnt       <= '0;
        txd       <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
        case (state)
          ST_START: if (bit_end) begin
            state   <= ST_DATA;
            cnt     <= '0;
            bit_idx <= '0;
            txd     <= shreg[0];
          end
          ST_DATA: if (bit_end) begin
            cnt <= '0;
            if (bit_idx == f_last) begin
              if (f_par_en) begin
                state <= ST_PAR;
                txd   <= f_par_bit;
              end else begin
                state <= ST_STOP;
                txd   <= 1'b1;
              end
            end else begin
              bit_idx <= bit_idx + IDX_W'(1);
              shreg   <= shreg >> 1;
              txd     <= shreg[1];
            end
          end
          ST_PAR: if (bit_end) begin
            state <= ST_STOP;
            cnt   <= '0;
            txd   <= 1'b1;
          end
          ST_STOP: if (stop_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
            txd   <= 1'b1;
          end
          default: begin
            cnt <= '0;
            txd <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts (
  input  logic clk,
  input  logic rst,
  input  logic rts_auto,
  input  logic accept,
  input  logic hold_full,
  input  logic frame_done,
  output logic rts
);
  always_ff @(posedge clk) begin
    if (rst)                      rts <= 1'b0;
    else if (!rts_auto)           rts <= 1'b0;
    else if (accept || hold_full) rts <= 1'b1;
    else if (frame_done)          rts <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_fstop.sv
module uart_tx_fstop #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          cts,
  input  logic          cts_gate,
  input  logic          rts_auto,
  input  logic [1:0]    char_len,
  input  logic [1:0]    par_mode,
  input  logic          par_odd,
  input  logic [3:0]    stop_code,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_emt,
  output logic          rts
);
  logic          enabled;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          accept;
  logic          take;
  logic          frame_done;
  logic          busy;

  uart_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .enabled(enabled), .hold_full(hold_full), .hold_data(hold_data),
    .accept(accept)
  );

  uart_tx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .hold_full(hold_full),
    .hold_data(hold_data), .cts(cts), .cts_gate(cts_gate),
    .char_len(char_len), .par_mode(par_mode), .par_odd(par_odd),
    .stop_code(stop_code), .take(take), .frame_done(frame_done),
    .busy(busy), .txd(txd)
  );

  uart_tx_rts u_rts (
    .clk(clk), .rst(rst), .rts_auto(rts_auto), .accept(accept),
    .hold_full(hold_full), .frame_done(frame_done), .rts(rts)
  );

  assign tx_rdy = enabled & ~hold_full;
  assign tx_emt = ~hold_full & ~busy;
endmodule

// File: rtl/uart_tx_fstop_chk.sv
module uart_tx_fstop_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          cmd_dis,
  input logic          cts,
  input logic          cts_gate,
  input logic          rts_auto,
  input logic          txd,
  input logic          tx_rdy,
  input logic          tx_emt,
  input logic          rts,
  input logic          take,
  input logic [DW-1:0] hold_data
);
  AST_DIS_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (rst) cmd_dis |=> !tx_rdy); // R6
  AST_ACCEPT_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst) (tx_rdy && wr_en) |=> !tx_rdy); // R7
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst) (wr_en && !tx_rdy) |=> $stable(hold_data)); // R7
  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst) tx_emt |-> txd); // R8
  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst) (take && cts_gate) |-> cts); // R9
  AST_RTS_MANUAL_LOW: assert property (@(posedge clk) disable iff (rst) !rts_auto |=> !rts); // R11
endmodule

bind uart_tx_fstop uart_tx_fstop_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_dis(cmd_dis), .cts(cts),
  .cts_gate(cts_gate), .rts_auto(rts_auto), .txd(txd), .tx_rdy(tx_rdy),
  .tx_emt(tx_emt), .rts(rts), .take(take), .hold_data(hold_data)
);

// File: tb/uart_tx_fstop_test.sv
module uart_tx_fstop_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_en = 1'b0, cmd_dis = 1'b0;
  logic       cts = 1'b1, cts_gate = 1'b0, rts_auto = 1'b0;
  logic [1:0] char_len = 2'd3, par_mode = 2'd2;
  logic       par_odd = 1'b0;
  logic [3:0] stop_code = 4'd7;
  logic       txd, tx_rdy, tx_emt, rts;

  int checks = 0, fails = 0, cyc = 0, tick_cnt = 0, low_cnt = 0, div = 0;

  uart_tx_fstop uut (.*);

  always #10 clk = ~clk;   // 50 MHz

  always @(negedge clk) begin
    div <= (div == 3) ? 0 : div + 1;
    tick16 <= (div == 3);
    if (txd === 1'b0) low_cnt <= low_cnt + 1;
  end

  always @(posedge clk) begin
    if (tick16) tick_cnt <= tick_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // stimulus table: data, len code, parity mode, odd, stop code, stop ticks
  typedef struct packed {
    logic [7:0] d; logic [1:0] len; logic [1:0] pm; logic odd;
    logic [3:0] sc; logic [5:0] nstop;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{8'hA5, 2'd3, 2'd0, 1'b0, 4'h7, 6'd16},
    '{8'h3C, 2'd2, 2'd1, 1'b1, 4'h0, 6'd9},
    '{8'h13, 2'd0, 2'd2, 1'b0, 4'h0, 6'd17},
    '{8'h0B, 2'd0, 2'd0, 1'b1, 4'h8, 6'd25},
    '{8'h7E, 2'd1, 2'd0, 1'b0, 4'hF, 6'd32},
    '{8'hFF, 2'd3, 2'd3, 1'b0, 4'h3, 6'd12},
    '{8'h55, 2'd0, 2'd1, 1'b0, 4'h7, 6'd24}
  };

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_cmd(input logic en, input logic dis);
    cmd_en = en; cmd_dis = dis;
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0;
  endtask

  task automatic wait_fall(output int t);
    while (txd !== 1'b0) @(negedge clk);
    t = tick_cnt;
  endtask

  task automatic wait_empty();
    while (tx_emt !== 1'b1) @(negedge clk);
  endtask

  // expected frame bits: start, data, parity, then one stop sample
  function automatic logic [10:0] build(input logic [7:0] d, input logic [1:0] len,
                                        input logic [1:0] pm, input logic odd,
                                        output int nb);
    logic [10:0] f; logic p; int nd;
    nd = 5 + len; f = '0; p = odd;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      p = p ^ d[i];
    end
    nb = 1 + nd;
    if (pm == 2'd0) begin f[nb] = p;   nb++; end
    else if (pm == 2'd1) begin f[nb] = odd; nb++; end
    f[nb] = 1'b1;
    return f;
  endfunction

  // called within a few cycles of the start edge
  task automatic get_frame(input int nb, output logic [10:0] got);
    got = '0;
    wait_ticks(8);
    got[0] = txd;
    for (int k = 1; k < nb; k++) begin
      wait_ticks(16);
      got[k] = txd;
    end
    wait_ticks(12);
    got[nb] = txd;
  endtask

  initial begin
    logic [10:0] exp_f, got;
    int nb, t1, t2, lc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1 && tx_rdy === 1'b0 && tx_emt === 1'b1 && rts === 1'b0,
        "R1 reset outputs", {txd, tx_rdy, tx_emt, rts}, 4'b1010);

    // R6 write while disabled is ignored
    wr(8'h42);
    lc = low_cnt;
    wait_ticks(60);
    chk(low_cnt == lc && tx_emt === 1'b1 && tx_rdy === 1'b0,
        "R6 disabled write ignored", low_cnt - lc, 0);

    pulse_cmd(1'b1, 1'b0);
    chk(tx_rdy === 1'b1, "R7 ready after enable", tx_rdy, 1);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      char_len = VT[v].len; par_mode = VT[v].pm; par_odd = VT[v].odd;
      stop_code = VT[v].sc;
      exp_f = build(VT[v].d, VT[v].len, VT[v].pm, VT[v].odd, nb);
      wr(VT[v].d);
      wait_fall(t1);
      wr(~VT[v].d);
      get_frame(nb, got);
      chk(got == exp_f, $sformatf("R2/R3 frame A vector %0d", v), got, exp_f);
      wait_fall(t2);
      chk(t2 - t1 == 16 * nb + VT[v].nstop, $sformatf("R4/R5 start gap vector %0d", v),
          t2 - t1, 16 * nb + VT[v].nstop);
      exp_f = build(~VT[v].d, VT[v].len, VT[v].pm, VT[v].odd, nb);
      get_frame(nb, got);
      chk(got == exp_f, $sformatf("R2/R3 frame B vector %0d", v), got, exp_f);
      wait_empty();
    end

    // R9 CTS gating and R7 full-hold write dropped
    char_len = 2'd3; par_mode = 2'd2; stop_code = 4'd7;
    cts_gate = 1'b1; cts = 1'b0;
    wr(8'hC3);
    chk(tx_rdy === 1'b0 && tx_emt === 1'b0, "R7 ready drops when held", tx_rdy, 0);
    wr(8'h99);
    lc = low_cnt;
    wait_ticks(50);
    chk(low_cnt == lc, "R9 no start while cts low", low_cnt - lc, 0);
    cts = 1'b1;
    exp_f = build(8'hC3, 2'd3, 2'd2, 1'b0, nb);
    wait_fall(t1);
    wr(8'h2D);
    cts = 1'b0;   // dropped mid-character
    get_frame(nb, got);
    chk(got == exp_f, "R7/R9 held char sent whole", got, exp_f);
    wait_ticks(30);
    lc = low_cnt;
    wait_ticks(60);
    chk(low_cnt == lc && tx_emt === 1'b0, "R9 next char waits for cts", low_cnt - lc, 0);
    cts = 1'b1;
    exp_f = build(8'h2D, 2'd3, 2'd2, 1'b0, nb);
    wait_fall(t1);
    get_frame(nb, got);
    chk(got == exp_f, "R9 char after cts returns", got, exp_f);
    wait_empty();
    cts_gate = 1'b0;
    chk(tx_emt === 1'b1 && txd === 1'b1, "R8 empty after drain", {tx_emt, txd}, 2'b11);

    // R10 disable during a character
    wr(8'h81);
    wait_fall(t1);
    wr(8'h7C);
    pulse_cmd(1'b1, 1'b1);   // both: disable wins
    chk(tx_rdy === 1'b0, "R6 disable wins over enable", tx_rdy, 0);
    exp_f = build(8'h81, 2'd3, 2'd2, 1'b0, nb);
    get_frame(nb, got);
    chk(got == exp_f, "R10 in-flight char completes", got, exp_f);
    exp_f = build(8'h7C, 2'd3, 2'd2, 1'b0, nb);
    wait_fall(t1);
    get_frame(nb, got);
    chk(got == exp_f, "R10 held char still sent", got, exp_f);
    wait_empty();
    wr(8'h00);
    lc = low_cnt;
    wait_ticks(60);
    chk(low_cnt == lc && tx_emt === 1'b1, "R10 line idle after disable", low_cnt - lc, 0);
    pulse_cmd(1'b1, 1'b0);

    // R11 automatic RTS
    rts_auto = 1'b1;
    @(negedge clk);
    chk(rts === 1'b0, "R11 rts low before write", rts, 0);
    wr(8'h5A);
    chk(rts === 1'b1, "R11 rts after accept", rts, 1);
    wait_fall(t1);
    wr(8'hA5);
    wait_fall(t2);
    wait_ticks(1);
    wait_fall(t2);
    chk(rts === 1'b1, "R11 rts held between chars", rts, 1);
    wait_empty();
    chk(rts === 1'b0, "R11 rts drops at end of stop", rts, 0);
    rts_auto = 1'b0;
    wr(8'h11);
    @(negedge clk);
    chk(rts === 1'b0, "R11 rts low in manual mode", rts, 0);
    wait_empty();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule